// File: doc/BRIEF.md
# Programmable Synchronous Memory Bus Sequencer

This block is a bus master. It takes single-word read and write requests from inside the chip and plays each one out as a cycle on a synchronous external memory bus. The bus carries chip enable, per-lane byte enables, an address, separate write-data and read-data paths with an output-enable for the pads, output enable, write enable, and one shared strobe line. That strobe line is either an address strobe or a read enable, depending on the mode. A set of configuration inputs controls the shape of each cycle:

- the read latency;
- the write latency;
- whether chip enable is held for the whole read;
- whether the strobe works in SRAM style or FIFO style;
- which of two bus clock-enable sources paces the bus.

With these settings the sequencer can drive a pipelined burst SRAM, a zero-turnaround SRAM, or a synchronous FIFO with glue logic.

Every bus output is a register that changes only on a `clk` edge where the selected bus tick is high. One bus cycle is therefore the run of `clk` cycles between two selected ticks. On a request, the first bus cycle is the command cycle (cycle 0). The data phase then falls in cycle L, where L is the programmed latency. Read data comes back on `rsp_rdata` together with a one-clock `rsp_done` pulse.

Top module: `sync_mem_seq`

## Requirements
- R1: After reset, and whenever the block is idle, the following hold: `bus_ce_n`, `bus_strb_n`, `bus_oe_n` and `bus_we_n` are 1; `bus_be_n` is all ones; `bus_dq_oe` is 0; `rsp_done` is 0.
- R2: For a read, `bus_dq_i` is captured at the selected-tick edge that ends bus cycle L = `cfg_rd_lat` (binary 0 to 3). In the `clk` cycle after that edge, `rsp_done` is 1 for exactly one clock and `rsp_rdata` holds the captured word. A write also gives one `rsp_done` pulse, after its data cycle.
- R3: For a write, `bus_we_n` is 0 in cycle 0 only. `bus_be_n` equals the inverse of `req_be` throughout the access, where bit i is byte lane i. `bus_dq_oe` is 1, with `bus_dq_o` equal to `req_wdata`, only in cycle L = `cfg_wr_lat` (0 to 3). A read drives `bus_be_n` all zero and never sets `bus_dq_oe`.
- R4: With `cfg_ce_hold` = 0, and on every write, `bus_ce_n` is 0 in cycle 0 only.
- R5: With `cfg_ce_hold` = 1, `bus_ce_n` is 0 on a read in every bus cycle where `bus_oe_n` is 0.
- R6: On a read, `bus_oe_n` is 0 from cycle 0 through cycle L. On a write, `bus_oe_n` stays 1.
- R7: With `cfg_fifo_mode` = 0 (SRAM style), `bus_strb_n` is 0 in the command cycle of every access. After cycle L, one deselect bus cycle follows, with `bus_strb_n` = 0 and `bus_ce_n` = 1, before the block is idle.
- R8: With `cfg_fifo_mode` = 1 (FIFO style), `bus_strb_n` is 0 only in the command cycle of a read and stays 1 for writes. No deselect cycle is added, so the bus is idle right after cycle L.
- R9: `cfg_clk_sel` = 0 selects `bclk_tick0` and 1 selects `bclk_tick1`. Bus outputs do not change across a `clk` edge at which the selected tick is 0.
- R10: `req_ready` is 1 exactly when the block is idle and the selected tick is 1. A request is accepted only when `req_valid` and `req_ready` are both 1. All configuration inputs are sampled at acceptance, and changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_lat | input | 2 | Read latency in bus cycles |
| cfg_wr_lat | input | 2 | Write latency in bus cycles |
| cfg_ce_hold | input | 1 | 1: chip enable follows output enable on reads |
| cfg_fifo_mode | input | 1 | 0: SRAM address strobe with deselect; 1: FIFO read enable |
| cfg_clk_sel | input | 1 | Bus tick source select |
| bclk_tick0 | input | 1 | Bus clock enable source 0 |
| bclk_tick1 | input | 1 | Bus clock enable source 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Word address |
| req_be | input | DW/8 | Byte lanes to write |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_done on reads |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_be_n | output | DW/8 | Byte enables, active low |
| bus_addr | output | AW | Bus address |
| bus_strb_n | output | 1 | Address strobe or FIFO read enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_dq_o | output | DW | Write data toward the pads |
| bus_dq_oe | output | 1 | Pad driver enable for bus_dq_o |
| bus_dq_i | input | DW | Read data from the pads |

## Verification
Several of the block's actions can land on the same edge.

- At latency 0, the command and the data phase share one bus cycle: a write strobes `bus_we_n` and drives data together, and a read issues its command and is captured at the same edge.
- The capture edge itself coincides either with the start of the SRAM deselect cycle or with the return to idle in FIFO mode.

The bench provokes these cases by sweeping both latencies from 0 to 3 in both modes, under both hold settings and both tick sources. Its bus model presents read data only in cycle L and drives inverted junk at all other times. A behavioural reference then judges every bus pin, the handshake and the completion pulse on every clock.

// File: rtl/smseq_pkg.sv
package smseq_pkg;
  localparam int LAT_W = 2;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ACT   = 2'd1,
    SQ_DESEL = 2'd2
  } sq_state_e;

  typedef struct packed {
    logic [LAT_W-1:0] rd_lat;
    logic [LAT_W-1:0] wr_lat;
    logic             ce_hold;
    logic             fifo;
    logic             clk_sel;
  } sq_cfg_t;
endpackage

// File: rtl/smseq_tick_sel.sv
module smseq_tick_sel #(
  parameter int N_SRC = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] srcs,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  generate
    if (N_SRC == 1) begin : g_single
      assign tick = srcs[0];
    end else begin : g_mux
      assign tick = srcs[sel];
    end
  endgenerate
endmodule

// File: rtl/smseq_phase_ctr.sv
module smseq_phase_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] k
);
  always_ff @(posedge clk) begin
    if (rst || clr) k <= '0;
    else if (inc)   k <= k + W'(1);
  end
endmodule

// File: rtl/smseq_rd_capture.sv
module smseq_rd_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic          is_read,
  input  logic [DW-1:0] dq_i,
  output logic          done,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= cap;
      if (cap && is_read) rdata <= dq_i;
    end
  end
endmodule

// File: rtl/sync_mem_seq.sv
module sync_mem_seq
  import smseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LAT_W-1:0] cfg_rd_lat,
  input  logic [LAT_W-1:0] cfg_wr_lat,
  input  logic             cfg_ce_hold,
  input  logic             cfg_fifo_mode,
  input  logic             cfg_clk_sel,
  input  logic             bclk_tick0,
  input  logic             bclk_tick1,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [BW-1:0]    req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic             bus_ce_n,
  output logic [BW-1:0]    bus_be_n,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_strb_n,
  output logic             bus_oe_n,
  output logic             bus_we_n,
  output logic [DW-1:0]    bus_dq_o,
  output logic             bus_dq_oe,
  input  logic [DW-1:0]    bus_dq_i
);

  typedef struct packed {
    logic          ce_n;
    logic          strb_n;
    logic          oe_n;
    logic          we_n;
    logic [BW-1:0] be_n;
    logic          dq_oe;
  } pin_t;

  localparam pin_t PINS_IDLE  = '{ce_n: 1'b1, strb_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, be_n: '1, dq_oe: 1'b0};
  localparam pin_t PINS_DESEL = '{ce_n: 1'b1, strb_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, be_n: '1, dq_oe: 1'b0};

  function automatic pin_t phase_pins(input logic wr, input logic [LAT_W-1:0] k,
                                      input logic [LAT_W-1:0] lat, input logic ce_hold,
                                      input logic fifo, input logic [BW-1:0] be);
    pin_t p;
    p.ce_n   = !((k == '0) || (!wr && ce_hold));
    p.strb_n = !((k == '0) && (!wr || !fifo));
    p.oe_n   = wr;
    p.we_n   = !(wr && (k == '0));
    p.be_n   = wr ? ~be : '0;
    p.dq_oe  = wr && (k == lat);
    return p;
  endfunction

  sq_state_e        st_q, st_d;
  sq_cfg_t          cfg_live, cfg_q, cfg_use;
  pin_t             pins_q, pins_d;
  logic             wr_q;
  logic [BW-1:0]    be_q;
  logic [LAT_W-1:0] k, lat_cur;
  logic             tick, k_clr, k_inc, cap, last;

  assign cfg_live = '{rd_lat: cfg_rd_lat, wr_lat: cfg_wr_lat, ce_hold: cfg_ce_hold,
                      fifo: cfg_fifo_mode, clk_sel: cfg_clk_sel};
  assign cfg_use  = (st_q == SQ_IDLE) ? cfg_live : cfg_q;

  smseq_tick_sel #(.N_SRC(2)) u_tick (
    .srcs ({bclk_tick1, bclk_tick0}),
    .sel  (cfg_use.clk_sel),
    .tick (tick)
  );

  assign req_ready = (st_q == SQ_IDLE) && tick;
  assign lat_cur   = wr_q ? cfg_q.wr_lat : cfg_q.rd_lat;
  assign last      = (k == lat_cur);

  always_comb begin
    st_d   = st_q;
    pins_d = PINS_IDLE;
    k_clr  = 1'b0;
    k_inc  = 1'b0;
    cap    = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (req_valid) begin
        st_d   = SQ_ACT;
        k_clr  = 1'b1;
        pins_d = phase_pins(req_write, '0, req_write ? cfg_live.wr_lat : cfg_live.rd_lat,
                            cfg_live.ce_hold, cfg_live.fifo, req_be);
      end
      SQ_ACT: if (last) begin
        cap = 1'b1;
        if (cfg_q.fifo) st_d = SQ_IDLE;
        else begin
          st_d   = SQ_DESEL;
          pins_d = PINS_DESEL;
        end
      end else begin
        k_inc  = 1'b1;
        pins_d = phase_pins(wr_q, k + LAT_W'(1), lat_cur, cfg_q.ce_hold, cfg_q.fifo, be_q);
      end
      SQ_DESEL: st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      pins_q   <= PINS_IDLE;
      cfg_q    <= '0;
      wr_q     <= 1'b0;
      be_q     <= '0;
      bus_addr <= '0;
      bus_dq_o <= '0;
    end else if (tick) begin
      st_q   <= st_d;
      pins_q <= pins_d;
      if (st_q == SQ_IDLE && req_valid) begin
        cfg_q    <= cfg_live;
        wr_q     <= req_write;
        be_q     <= req_be;
        bus_addr <= req_addr;
        bus_dq_o <= req_wdata;
      end
    end
  end

  smseq_phase_ctr #(.W(LAT_W)) u_ctr (
    .clk (clk),
    .rst (rst),
    .clr (tick && k_clr),
    .inc (tick && k_inc),
    .k   (k)
  );

  smseq_rd_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .cap     (tick && cap),
    .is_read (!wr_q),
    .dq_i    (bus_dq_i),
    .done    (rsp_done),
    .rdata   (rsp_rdata)
  );

  assign bus_ce_n   = pins_q.ce_n;
  assign bus_strb_n = pins_q.strb_n;
  assign bus_oe_n   = pins_q.oe_n;
  assign bus_we_n   = pins_q.we_n;
  assign bus_be_n   = pins_q.be_n;
  assign bus_dq_oe  = pins_q.dq_oe;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R2
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    bus_dq_oe |-> bus_oe_n); // R3
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_we_n) |=> bus_we_n); // R3
  AST_CE_FOLLOWS_OE: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.ce_hold && !bus_oe_n) |-> !bus_ce_n); // R5
  AST_FIFO_STRB_READ: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.fifo && !bus_strb_n) |-> !bus_oe_n); // R8
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({bus_ce_n, bus_strb_n, bus_oe_n, bus_we_n, bus_be_n, bus_dq_oe, bus_addr})); // R9
  AST_ACCEPT_CMD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !bus_ce_n); // R10

endmodule

// File: tb/sync_mem_seq_tb_top.sv
module sync_mem_seq_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_rd_lat = '0, cfg_wr_lat = '0;
  logic cfg_ce_hold = 0, cfg_fifo_mode = 0, cfg_clk_sel = 0;
  logic bclk_tick0 = 1, bclk_tick1 = 0;
  logic req_valid = 0, req_write = 0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic bus_ce_n, bus_strb_n, bus_oe_n, bus_we_n, bus_dq_oe;
  logic [BW-1:0] bus_be_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dq_o;
  logic [DW-1:0] bus_dq_i = '0;

  always #10 clk = ~clk;

  sync_mem_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat), .cfg_ce_hold(cfg_ce_hold),
    .cfg_fifo_mode(cfg_fifo_mode), .cfg_clk_sel(cfg_clk_sel),
    .bclk_tick0(bclk_tick0), .bclk_tick1(bclk_tick1),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_ce_n(bus_ce_n), .bus_be_n(bus_be_n), .bus_addr(bus_addr),
    .bus_strb_n(bus_strb_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  int c_rd, c_wr;
  bit c_ce, c_fifo, c_sel;
  bit finished = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] fq [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clk_step();
    @(negedge clk);
    cyc++;
    bclk_tick0 = (cyc % 3) != 2;
    bclk_tick1 = cyc[0];
  endtask

  function automatic bit tsel();
    return c_sel ? bclk_tick1 : bclk_tick0;
  endfunction

  task automatic drive_cfg(input bit flip);
    cfg_rd_lat    = flip ? ~2'(c_rd) : 2'(c_rd);
    cfg_wr_lat    = flip ? ~2'(c_wr) : 2'(c_wr);
    cfg_ce_hold   = c_ce ^ flip;
    cfg_fifo_mode = c_fifo ^ flip;
    cfg_clk_sel   = c_sel ^ flip;
  endtask

  // ph: 0 waiting, 1 active (cycle k), 2 deselect, 3 idle after access
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [BW-1:0] be,
                        input logic [DW-1:0] wd, input bit perturb);
    int L = wr ? c_wr : c_rd;
    int ph = 0, k = 0;
    bit exp_done = 0, nd, prev_t = 1;
    logic [DW-1:0] exp_rd = 32'h5A5A_A5A5;
    logic [63:0] snap, prev_snap = '0;
    bit e_ce, e_st, e_oe, e_we, e_dqoe;
    logic [BW-1:0] e_be;
    drive_cfg(0);
    if (!wr) exp_rd = c_fifo ? fq.pop_front() : mem[a[3:0]];
    else if (c_fifo) fq.push_back(wd);
    else for (int b = 0; b < BW; b++) if (be[b]) mem[a[3:0]][8*b +: 8] = wd[8*b +: 8];
    forever begin
      clk_step();
      if (ph == 0) begin
        req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
      end else req_valid = 0;
      drive_cfg(perturb && (ph == 1 || ph == 2));
      bus_dq_i = (ph == 1 && k == L && !wr) ? exp_rd : ~exp_rd;
      #1;
      e_ce = 1; e_st = 1; e_oe = 1; e_we = 1; e_be = '1; e_dqoe = 0;
      if (ph == 2) e_st = 0;
      else if (ph == 1) begin
        if (wr) begin
          e_ce = (k != 0); e_st = !(k == 0 && !c_fifo); e_we = (k != 0);
          e_be = ~be; e_dqoe = (k == L);
        end else begin
          e_ce = !(k == 0 || c_ce); e_st = (k != 0); e_oe = 0; e_be = '0;
        end
      end
      chk(bus_ce_n === e_ce, (c_ce && !wr) ? "R5" : "R4", "ce_n", 64'(bus_ce_n), 64'(e_ce));
      chk(bus_strb_n === e_st, c_fifo ? "R8" : "R7", "strb_n", 64'(bus_strb_n), 64'(e_st));
      chk(bus_oe_n === e_oe, "R6", "oe_n", 64'(bus_oe_n), 64'(e_oe));
      chk(bus_we_n === e_we, "R3", "we_n", 64'(bus_we_n), 64'(e_we));
      chk(bus_be_n === e_be, "R3", "be_n", 64'(bus_be_n), 64'(e_be));
      chk(bus_dq_oe === e_dqoe, "R3", "dq_oe", 64'(bus_dq_oe), 64'(e_dqoe));
      if (e_dqoe) chk(bus_dq_o === wd, "R3", "dq_o", 64'(bus_dq_o), 64'(wd));
      if (ph == 1) chk(bus_addr === a, "R10", "addr", 64'(bus_addr), 64'(a));
      if (ph == 0) chk(req_ready === tsel(), "R10", "ready", 64'(req_ready), 64'(tsel()));
      chk(rsp_done === exp_done, "R2", "done", 64'(rsp_done), 64'(exp_done));
      if (exp_done && !wr) chk(rsp_rdata === exp_rd, "R2", "rdata", 64'(rsp_rdata), 64'(exp_rd));
      snap = {bus_ce_n, bus_strb_n, bus_oe_n, bus_we_n, bus_be_n, bus_dq_oe, bus_addr};
      if (!prev_t) chk(snap === prev_snap, "R9", "hold", snap, prev_snap);
      prev_snap = snap;
      if (ph == 3) break;
      prev_t = tsel();
      nd = 0;
      if (prev_t) begin
        case (ph)
          0: begin ph = 1; k = 0; end
          1: if (k == L) begin nd = 1; ph = c_fifo ? 3 : 2; end else k++;
          2: ph = 3;
          default: ;
        endcase
      end
      exp_done = nd;
    end
    drive_cfg(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0101_0101 * i;
    repeat (3) @(negedge clk);
    rst = 0;
    clk_step();
    #1;
    // R1 reset state
    chk({bus_ce_n, bus_strb_n, bus_oe_n, bus_we_n} === 4'hF, "R1", "strobes", 64'({bus_ce_n, bus_strb_n, bus_oe_n, bus_we_n}), 64'hF);
    chk(bus_be_n === '1, "R1", "be_n", 64'(bus_be_n), 64'hF);
    chk(bus_dq_oe === 1'b0, "R1", "dq_oe", 64'(bus_dq_oe), 0);
    chk(rsp_done === 1'b0, "R1", "done", 64'(rsp_done), 0);
    for (int m = 0; m < 2; m++)
      for (int ce = 0; ce < 2; ce++)
        for (int lat = 0; lat < 4; lat++) begin
          c_fifo = m[0]; c_ce = ce[0]; c_rd = lat; c_wr = 3 - lat; c_sel = lat[0] ^ m[0];
          if (!c_fifo) begin
            access(1, 16'(lat + 4*ce), 4'hF, 32'hC0DE_0000 + 32'(lat * 17 + ce), 0);
            access(1, 16'(lat + 4*ce), 4'b0101, 32'hA5A5_5A5A ^ 32'(lat), lat == 1);
            access(0, 16'(lat + 4*ce), 4'hF, 32'h0, lat == 2);
            access(0, 16'(15 - lat), 4'hF, 32'h0, 0);
          end else begin
            access(1, 16'(lat), 4'hF, 32'hF1F0_0000 + 32'(lat), 0);
            access(1, 16'(lat), 4'hF, 32'h0E0F_0000 + 32'(lat * 3 + ce), lat == 3);
            access(0, 16'(lat), 4'hF, 32'h0, lat == 2);
            access(0, 16'(lat), 4'hF, 32'h0, 0);
          end
        end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule